// File: doc/BRIEF.md
# Page ECC Result Evaluator

The evaluator sits behind a NAND page transfer engine. When a page move finishes, the engine pulses `done_i` and presents two words. One is its transfer status word. The other is the error report word that the correction hardware produced for that page.

On that pulse the block captures both words and reduces them to a single registered verdict, which is one of three outcomes:
- a page that decoded cleanly, reported with the worst bit-flip count seen;
- a page that could not be corrected;
- an erased page, for which decoding is skipped.

The report holds one lane per packet group. The first packet of the page has its own lane, and every later packet shares a second lane. Each lane carries a success flag and a 6-bit error count. A saturating counter of uncorrectable pages runs beside the verdict path, and software can zero it with `clear_i`.

Top module: `page_ecc_verdict`

## Requirements
- R1: While and after reset, `valid_o`, `count_o`, `uncorr_o`, `empty_o` and `fails_o` are all zero.
- R2: `valid_o` is high for exactly the one cycle that follows each cycle in which `done_i` is high, and low otherwise.
- R3: When status bit 16 is 1, the verdict is erased: `empty_o`=1, `uncorr_o`=0 and `count_o`=0, whatever the report holds, and `fails_o` does not change.
- R4: With status bit 16 at 0, the report is read as two lanes. Bits 7..0 form the first-packet lane and bits 15..8 form the later-packets lane. In each lane the top bit is the success flag and the low 6 bits are the error count.
- R5: If both success flags (report bits 7 and 15) are 1, then `count_o` is the larger of report bits 5:0 and report bits 13:8, with `uncorr_o`=0 and `empty_o`=0.
- R6: If either success flag is 0 on a non-erased page, then `uncorr_o`=1, `count_o`=0 and `empty_o`=0.
- R7: Each uncorrectable verdict adds one to `fails_o`. Once the counter reaches all ones it stays there.
- R8: A `clear_i` pulse sets `fails_o` to zero in the next cycle. If an uncorrectable verdict arrives in the same cycle, the clear still wins.
- R9: Report bits 6, 14 and 31:16, and every status bit other than bit 16, have no effect on the verdict.
- R10: Between verdicts, `count_o`, `uncorr_o` and `empty_o` hold the values from the last verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Page transfer finished; capture status and report |
| status_i | input | STAT_W (32) | Transfer status word; bit 16 marks an erased page |
| report_i | input | RPT_W (32) | Error report word with two lanes |
| clear_i | input | 1 | Zero the failure counter |
| valid_o | output | 1 | One-cycle verdict strobe |
| count_o | output | 6 | Worst corrected bit-flip count |
| uncorr_o | output | 1 | Page could not be corrected |
| empty_o | output | 1 | Page is erased |
| fails_o | output | FAIL_W (16) | Saturating count of uncorrectable pages |

## Verification
The bench builds the block with FAIL_W set to 4, so the failure counter saturates after fifteen bad pages. This lets a short run drive the counter through its whole range, hold it at the ceiling, and then clear it. Lane widths and bit positions keep their defaults, so the vectors exercise the real bit positions. Those vectors place junk in the ignored report and status bits, and use both a count of 63 and unequal counts in either lane.

// File: rtl/pecc_pkg.sv
package pecc_pkg;
  localparam int CNT_W = 6;

  typedef struct packed {
    logic             empty;
    logic             uncorr;
    logic [CNT_W-1:0] count;
  } verdict_t;
endpackage

// File: rtl/pecc_report_decode.sv
module pecc_report_decode
  import pecc_pkg::*;
#(
  parameter int STAT_W    = 32,
  parameter int RPT_W     = 32,
  parameter int EMPTY_BIT = 16,
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 8
) (
  input  logic [STAT_W-1:0] status_i,
  input  logic [RPT_W-1:0]  report_i,
  output verdict_t          verdict_o
);
  localparam int OK_POS = LANE_W - 1;

  logic [NUM_LANES-1:0] lane_ok;
  logic [CNT_W-1:0]     lane_cnt [NUM_LANES];

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    assign lane_ok[k]  = report_i[k*LANE_W + OK_POS];
    assign lane_cnt[k] = report_i[k*LANE_W +: CNT_W];
  end

  logic [CNT_W-1:0] worst;
  always_comb begin
    worst = '0;
    for (int k = 0; k < NUM_LANES; k++)
      if (lane_cnt[k] > worst) worst = lane_cnt[k];
  end

  always_comb begin
    verdict_o = '0;
    if (status_i[EMPTY_BIT]) begin
      verdict_o.empty = 1'b1;          // erased page skips decoding
    end else if (&lane_ok) begin
      verdict_o.count = worst;
    end else begin
      verdict_o.uncorr = 1'b1;
    end
  end
endmodule

// File: rtl/pecc_fail_count.sv
module pecc_fail_count #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         bump_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    count_o <= '0;
    else if (clear_i)               count_o <= '0;
    else if (bump_i && count_o != TOP) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/page_ecc_verdict.sv
module page_ecc_verdict
  import pecc_pkg::*;
#(
  parameter int STAT_W    = 32,
  parameter int RPT_W     = 32,
  parameter int EMPTY_BIT = 16,
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 8,
  parameter int FAIL_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [RPT_W-1:0]  report_i,
  input  logic              clear_i,
  output logic              valid_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              uncorr_o,
  output logic              empty_o,
  output logic [FAIL_W-1:0] fails_o
);
  verdict_t next_v, cur_v;

  pecc_report_decode #(
    .STAT_W(STAT_W), .RPT_W(RPT_W), .EMPTY_BIT(EMPTY_BIT),
    .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)
  ) u_decode (
    .status_i (status_i),
    .report_i (report_i),
    .verdict_o(next_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_v   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) cur_v <= next_v;
    end
  end

  pecc_fail_count #(.W(FAIL_W)) u_fails (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .bump_i (done_i & next_v.uncorr),
    .count_o(fails_o)
  );

  assign count_o  = cur_v.count;
  assign uncorr_o = cur_v.uncorr;
  assign empty_o  = cur_v.empty;
endmodule

// File: rtl/pecc_checker.sv
module pecc_checker
  import pecc_pkg::*;
#(
  parameter int FAIL_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_i,
  input logic              clear_i,
  input logic              valid_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              uncorr_o,
  input logic              empty_o,
  input logic [FAIL_W-1:0] fails_o
);
  localparam logic [FAIL_W-1:0] TOP = '1;

  assert_strobe_follows_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(done_i));

  assert_erased_clean_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (!uncorr_o && count_o == '0));

  assert_uncorr_zero_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |-> (count_o == '0 && !empty_o));

  assert_fail_bump_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && uncorr_o && !$past(clear_i) && $past(fails_o) != TOP)
      |-> fails_o == $past(fails_o) + 1'b1);

  assert_fail_saturate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fails_o) == TOP && !$past(clear_i)) |-> fails_o == TOP);

  assert_clear_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> fails_o == '0);

  assert_hold_between_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(done_i) |-> ($stable(count_o) && $stable(uncorr_o) && $stable(empty_o)));
endmodule

bind page_ecc_verdict pecc_checker #(.FAIL_W(FAIL_W)) u_chk (.*);

// File: tb/page_ecc_verdict_test.sv
`timescale 1ns/1ps
module page_ecc_verdict_test;
  localparam int FW = 4;
  localparam int NV = 10;

  logic clk = 1'b0, rst_n = 1'b0, done = 1'b0, clear = 1'b0;
  logic [31:0] status = '0, report = '0;
  logic valid, uncorr, empty;
  logic [5:0] count;
  logic [FW-1:0] fails;

  int total = 0, bad = 0, exp_fails = 0;

  always #2.5 clk = ~clk;

  page_ecc_verdict #(.FAIL_W(FW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .status_i(status),
    .report_i(report), .clear_i(clear), .valid_o(valid), .count_o(count),
    .uncorr_o(uncorr), .empty_o(empty), .fails_o(fails)
  );

  // status, report, count, uncorr, empty
  typedef struct packed {
    logic [31:0] st; logic [31:0] rp; logic [5:0] c; logic u; logic e;
  } vec_t;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_8080, 6'd0,  1'b0, 1'b0},  // R5 zero
    '{32'h0000_0000, 32'h0000_8583, 6'd5,  1'b0, 1'b0},  // R5 later lane larger
    '{32'h0000_0000, 32'h0000_BFBF, 6'd63, 1'b0, 1'b0},  // R5 max count
    '{32'h0000_0000, 32'h0000_0085, 6'd0,  1'b1, 1'b0},  // R6 later flag low
    '{32'h0000_0000, 32'h0000_8205, 6'd0,  1'b1, 1'b0},  // R6 first flag low
    '{32'h0001_0000, 32'h0000_0000, 6'd0,  1'b0, 1'b1},  // R3
    '{32'hFFFF_FFFF, 32'h1234_5678, 6'd0,  1'b0, 1'b1},  // R3 report ignored
    '{32'hFFFE_FFFF, 32'hFFFF_C0C9, 6'd9,  1'b0, 1'b0},  // R9 junk bits, R4
    '{32'h0000_0000, 32'hFFFF_4141, 6'd0,  1'b1, 1'b0},  // R6 R9
    '{32'h0000_0000, 32'h0000_8A8C, 6'd12, 1'b0, 1'b0}   // R5 first lane larger
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bump_model(input logic u);
    if (u && exp_fails < (1 << FW) - 1) exp_fails++;
  endtask

  task automatic page(input vec_t v, input logic clr);
    @(negedge clk);
    done = 1'b1; status = v.st; report = v.rp; clear = clr;
    @(negedge clk);
    done = 1'b0; clear = 1'b0;
    status = 32'hDEAD_BEEF; report = 32'h0000_0000;
    if (clr) exp_fails = 0; else bump_model(v.u);
    chk("R2 valid", 32'(valid), 1);
    chk("R4 count", 32'(count), 32'(v.c));
    chk("R6 uncorr", 32'(uncorr), 32'(v.u));
    chk("R3 empty", 32'(empty), 32'(v.e));
    chk("R7 fails", 32'(fails), exp_fails);
    @(negedge clk);
    chk("R2 valid drop", 32'(valid), 0);
    chk("R10 hold count", 32'(count), 32'(v.c));
    chk("R10 hold flags", {30'd0, uncorr, empty}, {30'd0, v.u, v.e});
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk("R1 valid", 32'(valid), 0);
    chk("R1 fails", 32'(fails), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs", {valid, uncorr, empty, count}, 0);
    chk("R1 fails", 32'(fails), 0);

    for (int i = 0; i < NV; i++) page(VECS[i], 1'b0);

    // R7 saturation: drive many uncorrectable pages
    for (int i = 0; i < 16; i++) page(VECS[3], 1'b0);
    chk("R7 saturated", 32'(fails), (1 << FW) - 1);
    page(VECS[5], 1'b0);  // R3 erased leaves counter
    chk("R3 fails unchanged", 32'(fails), (1 << FW) - 1);

    // R8 plain clear
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0; exp_fails = 0;
    chk("R8 clear", 32'(fails), 0);
    page(VECS[4], 1'b0);
    chk("R7 after clear", 32'(fails), 1);
    // R8 clear beats simultaneous bump
    page(VECS[3], 1'b1);
    chk("R8 clear wins", 32'(fails), 0);

    // R10 idle hold
    repeat (5) @(negedge clk);
    chk("R10 idle", {valid, uncorr, empty, count}, {1'b0, 1'b1, 1'b0, 6'd0});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule